// File: doc/BRIEF.md
# Strap Latch and Clock-Control Decoder

This block sits beside the synthesizer core of a system clock generator. During power-on reset it samples the levels on a set of shared pins, which configure the part through board resistors. It holds those levels from the moment reset is released, and from that point the shared pins are handed over to the clock output drivers. The divider chains and PLL are outside this block. It only produces the control they need: one run enable for each clock output, an oscillator/VCO run flag, a four-bit frequency code, the source select for the super-I/O clock, a global high-impedance request and the pin direction controls.

A latched mode strap picks how four dual-purpose pins are used. In mobile mode they are active-low power-management inputs: CPU stop, PCI stop, SDRAM stop and power-down. In desktop mode they drive four extra SDRAM clocks and their stop functions are held inactive. The four power-management inputs are asynchronous, so each one passes through a synchronizer before it is decoded. Six configuration bytes written over the serial bus supply the frequency override, the tri-state request and the per-output enable bits.

Top module: `clk_ctl_decoder`

## Requirements
- R1: While porN is low, the strap register follows strapPin on every rising clock edge and strapPinOe is 0. On the first rising edge with porN high, strapPinOe becomes 1. After that, changes on strapPin have no effect on any output.
- R2: freqCode is {sdSel, fs2, fs1, fs0}, taken from latched strap bits {3,2,1,0}. When regFunc bit 3 is 1, freqCode is {regFunc[2], regFunc[6], regFunc[5], regFunc[4]} instead.
- R3: The latched mode strap is strapPin bit 4. When it is 0 (mobile), pmPinOe is 0, sdramRun[11:8] are 0 and pmPin acts as stop inputs. When it is 1 (desktop), pmPinOe is 1 after reset and pmPin has no effect on any output.
- R4: In mobile mode, pmPin[3] low (power-down) forces every run output to 0 and also forces oscRun to 0.
- R5: In mobile mode with power-down inactive, each stop input affects only its own group. pmPin[0] low clears cpuRun. pmPin[1] low clears pciRun but does not clear pciFreeRun. pmPin[2] low clears sdramRun.
- R6: A run output is 1 only when its enable bit is 1. The mapping is: cpuRun[i] from regCpu[i+1]; pciRun[i] from regPci[i]; pciFreeRun from regPci[6]; sdramRun[7:0] from regSdLo[7:0]; sdramRun[12:8] from regSdHi[4:0].
- R7: refRun[2:0] follow regPeri[2:0], ioapicRun follows regPeri[4], usbRun follows regSdHi[5] and sioRun follows regSdHi[6]. None of these outputs is affected by any stop input other than power-down.
- R8: sioSel24 equals the strap latched from strapPin bit 5. A value of 1 selects the 24 MHz source and 0 selects the 14.318 MHz source.
- R9: After reset, outHiZ equals regFunc bit 0.
- R10: A change on a pmPin input reaches the run outputs on the second rising clock edge after it is applied, not on the first.
- R11: While porN is low, every run output is 0, oscRun is 1 and pmPinOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| porN | input | 1 | Power-on reset, active low; straps are sampled while it is low |
| strapPin | input | 6 | Shared pin levels {sel24, mode, sdSel, fs2, fs1, fs0} |
| pmPin | input | 4 | Dual pins as inputs {pdN, sdramStopN, pciStopN, cpuStopN} |
| regFunc | input | 8 | Function byte: frequency override, tri-state request |
| regCpu | input | 8 | CPU clock enable byte |
| regPci | input | 8 | PCI clock enable byte |
| regSdLo | input | 8 | SDRAM 0-7 enable byte |
| regSdHi | input | 8 | SDRAM 8-12, 48 MHz and SIO enable byte |
| regPeri | input | 8 | REF and IOAPIC enable byte |
| cpuRun | output | 3 | CPU clock run enables |
| pciRun | output | 5 | Stoppable PCI clock run enables |
| pciFreeRun | output | 1 | Free-running PCI clock enable |
| sdramRun | output | 13 | SDRAM clock run enables |
| refRun | output | 3 | Reference clock run enables |
| ioapicRun | output | 1 | IOAPIC clock run enable |
| usbRun | output | 1 | 48 MHz clock run enable |
| sioRun | output | 1 | Super-I/O clock run enable |
| oscRun | output | 1 | Crystal oscillator and VCO run |
| sioSel24 | output | 1 | SIO source select, 1 = 24 MHz |
| outHiZ | output | 1 | Request to float all clock outputs |
| freqCode | output | 4 | Frequency select code to the synthesizer |
| strapPinOe | output | 1 | Shared pins switched to output |
| pmPinOe | output | 1 | Dual pins drive SDRAM clocks |

## Verification
Strap values only reach the outputs through a reset cycle, and the mode strap changes the meaning of the four dual pins. Because of this, the stimulus repeats a full power-on sequence for every one of the 64 strap patterns. It changes the strap pins in the same cycle that reset is released, which shows whether the capture window closes at the correct edge. The stop inputs are then swept through all 16 combinations, once in a mobile-mode session and once in a desktop-mode session. Each result is sampled two edges after the change so that it passes the synchronizer.

// File: rtl/cgd_pkg.sv
package cgd_pkg;
  localparam int N_CPU   = 3;
  localparam int N_PCI   = 5;
  localparam int N_SD    = 13;
  localparam int N_SD_LO = 8;
  localparam int N_REF   = 3;
  localparam int N_STRAP = 6;
  localparam int N_PM    = 4;
  // strap bit positions
  localparam int S_FS0   = 0;
  localparam int S_FS1   = 1;
  localparam int S_FS2   = 2;
  localparam int S_SDSEL = 3;
  localparam int S_MODE  = 4;
  localparam int S_SEL24 = 5;
  // dual-pin positions
  localparam int P_CPU   = 0;
  localparam int P_PCI   = 1;
  localparam int P_SD    = 2;
  localparam int P_PD    = 3;

  typedef struct packed {
    logic porDone;
    logic desktop;
    logic sel24;
    logic powerDown;
    logic cpuStop;
    logic pciStop;
    logic sdStop;
  } ctlStrobe_t;
endpackage

// File: rtl/cgd_ctrl.sv
module cgd_ctrl
  import cgd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               porN,
  input  logic [N_STRAP-1:0] strapPin,
  input  logic [N_PM-1:0]    pmPin,
  output ctlStrobe_t         strobe,
  output logic [3:0]         strapCode
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [N_STRAP-1:0] strapQ;
  logic               porDoneQ;
  logic [N_PM-1:0]    pmSync;
  logic               desktopMode;

  // strap capture window: open while reset is asserted
  always_ff @(posedge clk) begin
    if (!porN) strapQ <= strapPin;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) porDoneQ <= 1'b0;
    else       porDoneQ <= 1'b1;
  end

  // synchronizers for the asynchronous power-management inputs
  for (genvar p = 0; p < N_PM; p++) begin : g_sync
    logic [SYNC_MSB:0] shiftQ;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) shiftQ <= '1;
      else       shiftQ <= {shiftQ[SYNC_MSB-1:0], pmPin[p]};
    end
    assign pmSync[p] = shiftQ[SYNC_MSB];
  end

  assign desktopMode = strapQ[S_MODE];

  always_comb begin
    strobe           = '0;
    strobe.porDone   = porDoneQ;
    strobe.desktop   = desktopMode;
    strobe.sel24     = strapQ[S_SEL24];
    strobe.powerDown = porDoneQ & ~desktopMode & ~pmSync[P_PD];
    strobe.cpuStop   = ~desktopMode & ~pmSync[P_CPU];
    strobe.pciStop   = ~desktopMode & ~pmSync[P_PCI];
    strobe.sdStop    = ~desktopMode & ~pmSync[P_SD];
  end

  assign strapCode = {strapQ[S_SDSEL], strapQ[S_FS2], strapQ[S_FS1], strapQ[S_FS0]};

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!porN)
    porDoneQ |=> $stable(strapQ)); // R1

  AST_DESKTOP_NO_STOP: assert property (@(posedge clk) disable iff (!porN)
    (porDoneQ && desktopMode) |-> !(strobe.cpuStop || strobe.pciStop || strobe.sdStop || strobe.powerDown)); // R3
endmodule

// File: rtl/cgd_dp.sv
module cgd_dp
  import cgd_pkg::*;
(
  input  logic             clk,
  input  logic             porN,
  input  ctlStrobe_t       strobe,
  input  logic [3:0]       strapCode,
  input  logic [7:0]       regFunc,
  input  logic [7:0]       regCpu,
  input  logic [7:0]       regPci,
  input  logic [7:0]       regSdLo,
  input  logic [7:0]       regSdHi,
  input  logic [7:0]       regPeri,
  output logic [N_CPU-1:0] cpuRun,
  output logic [N_PCI-1:0] pciRun,
  output logic             pciFreeRun,
  output logic [N_SD-1:0]  sdramRun,
  output logic [N_REF-1:0] refRun,
  output logic             ioapicRun,
  output logic             usbRun,
  output logic             sioRun,
  output logic             oscRun,
  output logic             outHiZ,
  output logic [3:0]       freqCode
);
  logic liveAll;
  logic cpuLive;
  logic pciLive;
  logic sdLive;
  logic unusedRegBits;

  assign liveAll = strobe.porDone & ~strobe.powerDown;
  assign cpuLive = liveAll & ~strobe.cpuStop;
  assign pciLive = liveAll & ~strobe.pciStop;
  assign sdLive  = liveAll & ~strobe.sdStop;

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    assign cpuRun[i] = regCpu[i+1] & cpuLive;
  end

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    assign pciRun[i] = regPci[i] & pciLive;
  end
  assign pciFreeRun = regPci[6] & liveAll;

  for (genvar i = 0; i < N_SD; i++) begin : g_sd
    if (i < N_SD_LO) begin : g_lo
      assign sdramRun[i] = regSdLo[i] & sdLive;
    end else if (i == N_SD - 1) begin : g_top
      assign sdramRun[i] = regSdHi[i-N_SD_LO] & sdLive;
    end else begin : g_dual
      // dual-purpose pins drive clocks only in desktop mode
      assign sdramRun[i] = regSdHi[i-N_SD_LO] & sdLive & strobe.desktop;
    end
  end

  for (genvar i = 0; i < N_REF; i++) begin : g_ref
    assign refRun[i] = regPeri[i] & liveAll;
  end
  assign ioapicRun = regPeri[4] & liveAll;
  assign usbRun    = regSdHi[5] & liveAll;
  assign sioRun    = regSdHi[6] & liveAll;
  assign oscRun    = ~strobe.powerDown;
  assign outHiZ    = strobe.porDone & regFunc[0];

  always_comb begin
    if (regFunc[3]) freqCode = {regFunc[2], regFunc[6], regFunc[5], regFunc[4]};
    else            freqCode = strapCode;
  end

  assign unusedRegBits = ^{regFunc[7], regFunc[1], regCpu[7:4], regCpu[0],
                           regPci[7], regPci[5], regSdHi[7], regPeri[7:5], regPeri[3]};

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!porN)
    strobe.powerDown |-> (cpuRun == '0 && pciRun == '0 && !pciFreeRun && sdramRun == '0
                          && refRun == '0 && !ioapicRun && !usbRun && !sioRun && !oscRun)); // R4

  AST_PCIF_FREE: assert property (@(posedge clk) disable iff (!porN)
    (strobe.porDone && !strobe.powerDown && strobe.pciStop && regPci[6]) |-> pciFreeRun); // R5

  AST_CPU_STOP: assert property (@(posedge clk) disable iff (!porN)
    strobe.cpuStop |-> (cpuRun == '0)); // R5

  AST_MOBILE_SD_OFF: assert property (@(posedge clk) disable iff (!porN)
    !strobe.desktop |-> (sdramRun[11:8] == 4'b0)); // R3
endmodule

// File: rtl/clk_ctl_decoder.sv
module clk_ctl_decoder
  import cgd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         porN,
  input  logic [5:0]   strapPin,
  input  logic [3:0]   pmPin,
  input  logic [7:0]   regFunc,
  input  logic [7:0]   regCpu,
  input  logic [7:0]   regPci,
  input  logic [7:0]   regSdLo,
  input  logic [7:0]   regSdHi,
  input  logic [7:0]   regPeri,
  output logic [2:0]   cpuRun,
  output logic [4:0]   pciRun,
  output logic         pciFreeRun,
  output logic [12:0]  sdramRun,
  output logic [2:0]   refRun,
  output logic         ioapicRun,
  output logic         usbRun,
  output logic         sioRun,
  output logic         oscRun,
  output logic         sioSel24,
  output logic         outHiZ,
  output logic [3:0]   freqCode,
  output logic         strapPinOe,
  output logic         pmPinOe
);
  ctlStrobe_t strobe;
  logic [3:0] strapCode;

  cgd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .porN(porN), .strapPin(strapPin), .pmPin(pmPin),
    .strobe(strobe), .strapCode(strapCode)
  );

  cgd_dp u_dp (
    .clk(clk), .porN(porN), .strobe(strobe), .strapCode(strapCode),
    .regFunc(regFunc), .regCpu(regCpu), .regPci(regPci),
    .regSdLo(regSdLo), .regSdHi(regSdHi), .regPeri(regPeri),
    .cpuRun(cpuRun), .pciRun(pciRun), .pciFreeRun(pciFreeRun),
    .sdramRun(sdramRun), .refRun(refRun), .ioapicRun(ioapicRun),
    .usbRun(usbRun), .sioRun(sioRun), .oscRun(oscRun),
    .outHiZ(outHiZ), .freqCode(freqCode)
  );

  assign sioSel24   = strobe.sel24;
  assign strapPinOe = strobe.porDone;
  assign pmPinOe    = strobe.porDone & strobe.desktop;
endmodule

// File: tb/clk_ctl_decoder_tb.sv
`timescale 1ns/1ps
module clk_ctl_decoder_tb;
  logic        clk = 1'b0;
  logic        porN;
  logic [5:0]  strapPin;
  logic [3:0]  pmPin;
  logic [7:0]  regFunc, regCpu, regPci, regSdLo, regSdHi, regPeri;
  logic [2:0]  cpuRun;
  logic [4:0]  pciRun;
  logic        pciFreeRun;
  logic [12:0] sdramRun;
  logic [2:0]  refRun;
  logic        ioapicRun, usbRun, sioRun, oscRun, sioSel24, outHiZ;
  logic [3:0]  freqCode;
  logic        strapPinOe, pmPinOe;
  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;

  clk_ctl_decoder u_dut (
    .clk(clk), .porN(porN), .strapPin(strapPin), .pmPin(pmPin),
    .regFunc(regFunc), .regCpu(regCpu), .regPci(regPci), .regSdLo(regSdLo),
    .regSdHi(regSdHi), .regPeri(regPeri), .cpuRun(cpuRun), .pciRun(pciRun),
    .pciFreeRun(pciFreeRun), .sdramRun(sdramRun), .refRun(refRun),
    .ioapicRun(ioapicRun), .usbRun(usbRun), .sioRun(sioRun), .oscRun(oscRun),
    .sioSel24(sioSel24), .outHiZ(outHiZ), .freqCode(freqCode),
    .strapPinOe(strapPinOe), .pmPinOe(pmPinOe)
  );

  function automatic logic [28:0] observed();
    return {cpuRun, pciRun, pciFreeRun, sdramRun, refRun, ioapicRun, usbRun, sioRun, oscRun};
  endfunction

  // expected run vector from the requirements (mobile/desktop, stop pins, enable bytes)
  function automatic logic [28:0] expRuns(input logic [3:0] pm, input logic desk);
    logic pd, cs, ps, ss, live;
    logic [2:0] c; logic [4:0] p; logic [12:0] sd; logic [2:0] r;
    pd = !desk && !pm[3];
    cs = !desk && !pm[0];
    ps = !desk && !pm[1];
    ss = !desk && !pm[2];
    live = !pd;
    c  = (live && !cs) ? regCpu[3:1] : 3'b0;
    p  = (live && !ps) ? regPci[4:0] : 5'b0;
    sd = {regSdHi[4:0], regSdLo};
    if (!desk) sd[11:8] = 4'b0;
    if (!live || ss) sd = '0;
    r  = live ? regPeri[2:0] : 3'b0;
    return {c, p, live & regPci[6], sd, r, live & regPeri[4], live & regSdHi[5],
            live & regSdHi[6], live};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doPor(input logic [5:0] s);
    @(negedge clk);
    porN = 1'b0; strapPin = s; pmPin = 4'hF;
    repeat (2) @(negedge clk);
    porN = 1'b1; strapPin = ~s;
    repeat (3) @(negedge clk);
  endtask

  task automatic setAll(input logic [7:0] v);
    regFunc = 8'h00; regCpu = v; regPci = v; regSdLo = v; regSdHi = v; regPeri = v;
  endtask

  initial begin
    #(200000 * 5);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks + 1);
    $finish;
  end

  initial begin
    porN = 1'b0; strapPin = 6'h00; pmPin = 4'hF; setAll(8'hFF);
    repeat (3) @(negedge clk);
    // R11 / R1: state during reset
    chk(observed() == 29'h1, "R11 runs during reset", 32'(observed()), 32'h1);
    chk(!strapPinOe && !pmPinOe, "R1 pin direction in reset", {30'b0, strapPinOe, pmPinOe}, 0);

    // R1 R2 R3 R8: every strap pattern through a full power-on sequence
    for (int s = 0; s < 64; s++) begin
      doPor(6'(s));
      chk(freqCode == 4'(s), "R2 strap freq code", 32'(freqCode), 32'(s & 15));
      chk(sioSel24 == s[5], "R8 sio select", 32'(sioSel24), 32'(s[5]));
      chk(pmPinOe == s[4], "R3 dual pin direction", 32'(pmPinOe), 32'(s[4]));
      chk(strapPinOe == 1'b1, "R1 shared pins output", 32'(strapPinOe), 1);
    end

    // R1: later strap changes have no effect
    doPor(6'b001010);
    strapPin = 6'b110101;
    repeat (2) @(negedge clk);
    chk(freqCode == 4'hA && !sioSel24 && !pmPinOe, "R1 straps frozen",
        {26'b0, sioSel24, pmPinOe, freqCode}, 32'hA);

    // R4 R5: mobile mode stop sweep
    for (int m = 0; m < 16; m++) begin
      pmPin = 4'(m);
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      chk(observed() == expRuns(4'(m), 1'b0), "R4 R5 mobile stop sweep",
          32'(observed()), 32'(expRuns(4'(m), 1'b0)));
    end

    // R10: synchronizer latency of two edges
    pmPin = 4'hF;
    repeat (3) @(negedge clk);
    pmPin = 4'b1110;
    @(posedge clk); @(negedge clk);
    chk(cpuRun == 3'b111, "R10 no change after one edge", 32'(cpuRun), 7);
    @(posedge clk); @(negedge clk);
    chk(cpuRun == 3'b000, "R10 change after two edges", 32'(cpuRun), 0);
    pmPin = 4'hF;
    repeat (3) @(negedge clk);

    // R6 R7: walking-zero over every enable byte
    for (int b = 0; b < 5; b++) begin
      for (int k = 0; k < 8; k++) begin
        setAll(8'hFF);
        case (b)
          0: regCpu  = ~(8'd1 << k);
          1: regPci  = ~(8'd1 << k);
          2: regSdLo = ~(8'd1 << k);
          3: regSdHi = ~(8'd1 << k);
          default: regPeri = ~(8'd1 << k);
        endcase
        #1;
        chk(observed() == expRuns(4'hF, 1'b0), (b >= 3) ? "R7 enable walk" : "R6 enable walk",
            32'(observed()), 32'(expRuns(4'hF, 1'b0)));
      end
    end
    setAll(8'hFF);

    // R2 R9: function byte sweep
    for (int f = 0; f < 256; f++) begin
      logic [3:0] eCode;
      regFunc = 8'(f);
      #1;
      eCode = f[3] ? {f[2], f[6], f[5], f[4]} : 4'hA;
      chk(freqCode == eCode, "R2 override code", 32'(freqCode), 32'(eCode));
      chk(outHiZ == f[0], "R9 tri-state", 32'(outHiZ), 32'(f[0]));
    end
    regFunc = 8'h00;

    // R3: desktop mode ignores the dual pins and enables the extra SDRAM clocks
    doPor(6'b010000);
    chk(pmPinOe == 1'b1, "R3 desktop direction", 32'(pmPinOe), 1);
    for (int m = 0; m < 16; m++) begin
      pmPin = 4'(m);
      repeat (2) begin @(posedge clk); @(negedge clk); end
      chk(observed() == expRuns(4'(m), 1'b1), "R3 desktop stop ignored",
          32'(observed()), 32'(expRuns(4'(m), 1'b1)));
    end

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule